// File: doc/BRIEF.md
# Sprite Vertical-Data Shadow Cache

This block keeps an on-chip copy of the vertical half of every sprite descriptor. It does not fetch anything itself. It snoops each write on the video-memory write bus, and when the byte address falls inside the sprite table window that the current base register defines, it captures the data. Only two of the four words of a descriptor are kept: the vertical position, and the word that carries size and link. The line-selection logic reads these words through a registered port indexed by sprite number, so it needs no video-memory bandwidth.

The horizontal position and the attribute word are never cached. A combinational request port turns a sprite number into the video-memory byte address of either word, always from the base register's present value.

Moving the base leaves the cached contents as they are. Vertical data written under an earlier base therefore stays in force until software rewrites the matching bytes inside the new window. Horizontal and attribute fetches follow the new base at once.

Top module: `sprite_vcache`

## Requirements
- R1: Each descriptor is 8 bytes at base + 8*n. The word at offset 0 supplies `rd_ypos` = data[9:0]. The word at offset 2 supplies `rd_size` = data[11:8] and `rd_link` = data[6:0]. Writes to offsets 4 and 6 change no read result.
- R2: A write is captured only if base <= address < base+512 when `wide` is 0, or base <= address < base+640 when `wide` is 1. Any other write changes no entry.
- R3: A write with `wr_dma` = 1 is captured exactly as one with `wr_dma` = 0.
- R4: Changing `base` or `wide` never clears, invalidates or reloads any cached entry.
- R5: `attr_addr` = base + 8*`attr_idx` + 4 when `attr_hpos` = 0, or + 6 when `attr_hpos` = 1, using the current base.
- R6: Sequence: base A, list 1 written at A, list 2 written at B, base moved to B, list 3 written at A. Reads then return list 1 vertical data, and `attr_addr` points into B.
- R7: After the base moves, writes inside the new window update the cached vertical and size data.
- R8: `wr_be[0]` enables data[7:0] and `wr_be[1]` enables data[15:8]. A disabled byte keeps its cached value.
- R9: After reset every entry reads as zero.
- R10: The read port has one cycle of latency. A read issued in the cycle after a write returns the written data. A read issued in the same cycle as the write returns the old data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Video-memory write strobe |
| wr_dma | input | 1 | Write comes from DMA (1) or the processor (0) |
| wr_addr | input | 16 | Byte address of the write |
| wr_data | input | 16 | Write data word |
| wr_be | input | 2 | Byte enables: bit 1 high byte, bit 0 low byte |
| base | input | 16 | Sprite table base, 8-byte aligned |
| wide | input | 1 | 80-entry window when 1, 64-entry when 0 |
| rd_idx | input | 7 | Sprite number to read |
| rd_ypos | output | 10 | Cached vertical position |
| rd_size | output | 4 | Cached size |
| rd_link | output | 7 | Cached link |
| attr_idx | input | 7 | Sprite number for the horizontal/attribute fetch |
| attr_hpos | input | 1 | Select horizontal word (1) or attribute word (0) |
| attr_addr | output | 16 | Video-memory byte address for that fetch |

## Verification
The hardest case to reach is the split between the two halves of a descriptor. Vertical data comes from one table while horizontal and attribute addresses point at another. This only shows after a base move that the writes before and after the move have set up on purpose. The bench plays the three-list sequence through the write bus. It then checks that writes to the old region, now outside the window, leave the cache alone, and that a rewrite inside the new window takes effect. Window edges get their own writes: the byte just below the base, the first byte past 512 and past 640, and an offset of 1024 that would alias onto entry 0 if the index were truncated.

// File: rtl/sprite_vcache.sv
module sprite_vcache #(
  parameter int ADDR_W    = 16,
  parameter int NARROW_N  = 64,
  parameter int WIDE_N    = 80,
  parameter int IDX_W     = $clog2(WIDE_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_dma,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [1:0]        wr_be,
  input  logic [ADDR_W-1:0] base,
  input  logic              wide,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [9:0]        rd_ypos,
  output logic [3:0]        rd_size,
  output logic [6:0]        rd_link,
  input  logic [IDX_W-1:0]  attr_idx,
  input  logic              attr_hpos,
  output logic [ADDR_W-1:0] attr_addr
);
  localparam int NARROW_LIM = NARROW_N * 8;
  localparam int WIDE_LIM   = WIDE_N * 8;

  logic [ADDR_W:0]   off;
  logic [ADDR_W-1:0] lim;
  logic              hit;
  logic [IDX_W-1:0]  wr_idx;
  logic              cap_y, cap_s;
  logic [15:0]       ytab [WIDE_N];
  logic [15:0]       stab [WIDE_N];
  logic [15:0]       rw0, rw1;

  assign off    = {1'b0, wr_addr} - {1'b0, base};
  assign lim    = wide ? ADDR_W'(WIDE_LIM) : ADDR_W'(NARROW_LIM);
  assign hit    = wr_en && !off[ADDR_W] && (off[ADDR_W-1:0] < lim);
  assign wr_idx = off[IDX_W+2:3];
  assign cap_y  = hit && off[2:1] == 2'd0;
  assign cap_s  = hit && off[2:1] == 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIDE_N; i++) begin
        ytab[i] <= '0;
        stab[i] <= '0;
      end
    end else begin
      if (cap_y) begin
        if (wr_be[0]) ytab[wr_idx][7:0]  <= wr_data[7:0];
        if (wr_be[1]) ytab[wr_idx][15:8] <= wr_data[15:8];
      end
      if (cap_s) begin
        if (wr_be[0]) stab[wr_idx][7:0]  <= wr_data[7:0];
        if (wr_be[1]) stab[wr_idx][15:8] <= wr_data[15:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rw0 <= '0;
      rw1 <= '0;
    end else if (int'(rd_idx) < WIDE_N) begin
      rw0 <= ytab[rd_idx];
      rw1 <= stab[rd_idx];
    end else begin
      rw0 <= '0;
      rw1 <= '0;
    end
  end

  assign rd_ypos = rw0[9:0];
  assign rd_size = rw1[11:8];
  assign rd_link = rw1[6:0];

  assign attr_addr = base + ADDR_W'({attr_idx, 3'b000}) + (attr_hpos ? ADDR_W'(6) : ADDR_W'(4));

  wire unused_ok = &{1'b0, off[0], wr_dma, rw0[15:10], rw1[15:12], rw1[7]};

  assert_idx_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(wr_idx) < (wide ? WIDE_N : NARROW_N)));

  assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(rd_idx)) |=> ($stable(rd_ypos) && $stable(rd_size) && $stable(rd_link)));

  assert_attr_word_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (base[2:0] == 3'd0) |-> (attr_addr[2:0] == {1'b1, attr_hpos, 1'b0}));

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_y && wr_be == 2'b11, 2) && $past(rd_idx) == $past(wr_idx, 2))
      |-> (rd_ypos == $past(wr_data[9:0], 2)));

  assert_dma_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_s && wr_dma && wr_be == 2'b11, 2) && $past(rd_idx) == $past(wr_idx, 2))
      |-> (rd_link == $past(wr_data[6:0], 2) && rd_size == $past(wr_data[11:8], 2)));
endmodule

// File: tb/sprite_vcache_bench.sv
module sprite_vcache_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, wr_dma = 0, wide = 0, attr_hpos = 0;
  logic [15:0] wr_addr = 0, wr_data = 0, base = 16'hC000;
  logic [1:0]  wr_be = 0;
  logic [6:0]  rd_idx = 0, attr_idx = 0;
  logic [9:0]  rd_ypos;
  logic [3:0]  rd_size;
  logic [6:0]  rd_link;
  logic [15:0] attr_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sprite_vcache u_sprite_vcache (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dma(wr_dma), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .base(base), .wide(wide), .rd_idx(rd_idx),
    .rd_ypos(rd_ypos), .rd_size(rd_size), .rd_link(rd_link),
    .attr_idx(attr_idx), .attr_hpos(attr_hpos), .attr_addr(attr_addr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d, logic [1:0] be = 2'b11, logic dma = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_be = be; wr_dma = dma;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [6:0] i, output logic [9:0] y, output logic [3:0] s, output logic [6:0] l);
    @(negedge clk);
    rd_idx = i;
    @(negedge clk);
    y = rd_ypos; s = rd_size; l = rd_link;
  endtask

  task automatic t_reset();
    logic [9:0] y; logic [3:0] s; logic [6:0] l;
    rd(0, y, s, l);  chk("R9 entry0", {y, s, l}, 0);
    rd(79, y, s, l); chk("R9 entry79", {y, s, l}, 0);
  endtask

  task automatic t_fields();
    logic [9:0] y; logic [3:0] s; logic [6:0] l;
    base = 16'hC000; wide = 0;
    wr(16'hC018, 16'hFD55);
    wr(16'hC01A, 16'hFA85);
    rd(3, y, s, l);
    chk("R1 ypos", y, 10'h155); chk("R1 size", s, 4'hA); chk("R1 link", l, 7'h05);
    wr(16'hC01C, 16'h0000);
    wr(16'hC01E, 16'h1234);
    rd(3, y, s, l);
    chk("R1 words 2/3 ignored", {y, s, l}, {10'h155, 4'hA, 7'h05});
  endtask

  task automatic t_window();
    logic [9:0] y; logic [3:0] s; logic [6:0] l;
    base = 16'hC000; wide = 0;
    wr(16'hC200, 16'h0111);
    wide = 1;
    rd(64, y, s, l); chk("R2 narrow ends at +512", y, 0);
    wr(16'hC200, 16'h0122);
    rd(64, y, s, l); chk("R2 wide includes +512", y, 10'h122);
    wr(16'hC278, 16'h0133);
    rd(79, y, s, l); chk("R2 wide last entry", y, 10'h133);
    wr(16'hC000, 16'h0001);
    wr(16'hC280, 16'h03FF);
    wr(16'hC400, 16'h03EE);
    wr(16'hBFF8, 16'h03DD);
    rd(0, y, s, l); chk("R2 outside window ignored", y, 10'h001);
    rd(79, y, s, l); chk("R2 below base ignored", y, 10'h133);
    wide = 0;
  endtask

  task automatic t_dma();
    logic [9:0] y; logic [3:0] s; logic [6:0] l;
    base = 16'hC000;
    wr(16'hC028, 16'h0077, 2'b11, 1);
    wr(16'hC02A, 16'h0C3F, 2'b11, 1);
    rd(5, y, s, l);
    chk("R3 dma write captured", {y, s, l}, {10'h077, 4'hC, 7'h3F});
  endtask

  task automatic t_bytes();
    logic [9:0] y; logic [3:0] s; logic [6:0] l;
    base = 16'hC000;
    wr(16'hC030, 16'h03FF);
    wr(16'hC030, 16'h0012, 2'b01);
    rd(6, y, s, l); chk("R8 low byte only", y, 10'h312);
    wr(16'hC030, 16'h0100, 2'b10);
    rd(6, y, s, l); chk("R8 high byte only", y, 10'h112);
  endtask

  task automatic t_attr();
    base = 16'hC000; attr_idx = 5; attr_hpos = 0;
    #1 chk("R5 attribute word", attr_addr, 16'hC02C);
    attr_hpos = 1;
    #1 chk("R5 hpos word", attr_addr, 16'hC02E);
  endtask

  task automatic t_sequence();
    logic [9:0] y; logic [3:0] s; logic [6:0] l;
    base = 16'hC000; wide = 0;
    for (int i = 0; i < 3; i++) begin
      wr(16'hC000 + 16'(i * 8), 16'h0100 + 16'(i));
      wr(16'hC002 + 16'(i * 8), 16'h0200 + 16'(i));
    end
    for (int i = 0; i < 3; i++) wr(16'hD000 + 16'(i * 8), 16'h0300 + 16'(i));
    base = 16'hD000;
    for (int i = 0; i < 3; i++) wr(16'hC000 + 16'(i * 8), 16'h0050 + 16'(i));
    rd(1, y, s, l);
    chk("R6 ypos from list 1", y, 10'h101);
    chk("R4 size/link kept after base move", {s, l}, {4'h2, 7'h01});
    attr_idx = 1; attr_hpos = 1;
    #1 chk("R6 hpos address in list 2", attr_addr, 16'hD00E);
    wr(16'hD008, 16'h02AB);
    rd(1, y, s, l); chk("R7 rewrite at new base", y, 10'h2AB);
  endtask

  task automatic t_latency();
    @(negedge clk);
    wr_en = 1; wr_addr = 16'hD010; wr_data = 16'h0345; wr_be = 2'b11; rd_idx = 2;
    @(negedge clk);
    wr_en = 0;
    chk("R10 same-cycle read gives old", rd_ypos, 10'h102);
    @(negedge clk);
    chk("R10 next-cycle read gives new", rd_ypos, 10'h345);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fields();
    t_window();
    t_dma();
    t_bytes();
    t_attr();
    t_sequence();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule